// File: doc/BRIEF.md
# Dual-Edge Demodulation Capture Timer

This block times an external signal against the system clock. While enabled it sits idle until a chosen edge of the timer input appears. That edge starts a 16-bit up-counter from zero. After that, every rising edge of the input copies the running count into a rise capture register, and every falling edge copies it into a fall capture register. Each copy raises a one-cycle strobe for the register it wrote.

A single-edge mode picks the starting edge with a polarity bit. A both-edges mode lets either edge start the count and ignores the polarity bit. The input is asynchronous and passes through a two-flop synchronizer inside the block.

Software reads the two registers to get pulse widths and periods. Interrupt generation, glitch filtering and register access are left to the surrounding logic.

Top module: `edcap_timer`

## Requirements
- R1: During and after asynchronous reset (rst_ni low), both capture registers read 0, both strobes are low and the block waits for a start edge.
- R2: With both_i=0 and pol_i=0, a rising input edge (0 to 1) starts the count and a falling edge does not.
- R3: With both_i=0 and pol_i=1, a falling input edge (1 to 0) starts the count and a rising edge does not.
- R4: With both_i=1, an edge of either direction starts the count, whatever pol_i is.
- R5: Once counting, each rising input edge loads the current count into cap_rise_o and pulses rise_vld_o.
- R6: Once counting, each falling input edge loads the current count into cap_fall_o and pulses fall_vld_o.
- R7: The count is 0 in the cycle after the start edge is detected and rises by 1 per clock. An edge that follows the start edge by d input cycles therefore captures d-1. A strobe goes high on the third rising clock edge after the input changes.
- R8: The count wraps from 0xFFFF to 0x0000 and keeps going.
- R9: Each strobe lasts exactly one clock cycle per capture.
- R10: The edge that starts the count causes no capture and no strobe.
- R11: While en_i is low, nothing is captured, the registers hold their values and the block drops back to waiting. After en_i returns high, counting restarts from 0 only after a new start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tin_i | input | 1 | Asynchronous timer input |
| en_i | input | 1 | Timer enable |
| pol_i | input | 1 | Start edge in single-edge mode: 0 rising, 1 falling |
| both_i | input | 1 | 1 selects both-edges start mode |
| cap_rise_o | output | 16 | Count captured on the last rising edge |
| cap_fall_o | output | 16 | Count captured on the last falling edge |
| rise_vld_o | output | 1 | One-cycle strobe: cap_rise_o updated |
| fall_vld_o | output | 1 | One-cycle strobe: fall_vld_o's register cap_fall_o updated |

## Verification
Two states are hard to reach from the pins. The first is the count rolling over, which needs more than 65536 clock cycles between a start edge and a capturing edge. The stimulus holds the input still for 65541 cycles, so the expected capture is 4.

The second is the return to idle after a disable. The bench drops en_i mid-count and toggles the input while disabled, which must leave the registers untouched. It then re-enables and checks that the first edge only restarts the count from zero and causes no capture.

// File: rtl/edcap_pkg.sv
package edcap_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } run_st_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  localparam int unsigned NSLOT     = 2;
  localparam int unsigned SLOT_RISE = 0;
  localparam int unsigned SLOT_FALL = 1;
endpackage

// File: rtl/edcap_sync.sv
module edcap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q[0] <= 1'b0;
          else         q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q[i] <= 1'b0;
          else         q[i] <= q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/edcap_edge.sv
module edcap_edge
  import edcap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  output edge_t edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign edge_o.rise = lvl_i & ~prev_q;
  assign edge_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/edcap_trig.sv
module edcap_trig
  import edcap_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic         both_i,
  input  edge_t        edge_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o
);
  run_st_e      st_q;
  logic [W-1:0] cnt_q;
  logic         start;

  // start edge selection; polarity ignored in both-edges mode
  always_comb begin
    if (both_i)     start = edge_i.rise | edge_i.fall;
    else if (pol_i) start = edge_i.fall;
    else            start = edge_i.rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
    end else if (!en_i) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_WAIT: begin
          if (start) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end
        end
        ST_RUN:  cnt_q <= cnt_q + 1'b1;
        default: st_q  <= ST_WAIT;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = (st_q == ST_RUN);
endmodule

// File: rtl/edcap_bank.sv
module edcap_bank
  import edcap_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cap_en_i,
  input  edge_t                     edge_i,
  input  logic [W-1:0]              cnt_i,
  output logic [NSLOT-1:0][W-1:0]   val_o,
  output logic [NSLOT-1:0]          vld_o
);
  logic [NSLOT-1:0] hit;

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i == SLOT_RISE) begin : g_rise
        assign hit[i] = edge_i.rise;
      end else begin : g_fall
        assign hit[i] = edge_i.fall;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          val_o[i] <= '0;
          vld_o[i] <= 1'b0;
        end else begin
          vld_o[i] <= cap_en_i & hit[i];
          if (cap_en_i && hit[i]) val_o[i] <= cnt_i;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/edcap_timer.sv
module edcap_timer
  import edcap_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tin_i,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic         both_i,
  output logic [W-1:0] cap_rise_o,
  output logic [W-1:0] cap_fall_o,
  output logic         rise_vld_o,
  output logic         fall_vld_o
);
  logic                    tin_s;
  edge_t                   edg;
  logic                    edg_rise, edg_fall;
  logic [W-1:0]            cnt_q;
  logic                    run_q;
  logic                    cap_en;
  logic [NSLOT-1:0][W-1:0] val;
  logic [NSLOT-1:0]        vld;

  edcap_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tin_i),
    .q_o   (tin_s)
  );

  edcap_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (tin_s),
    .edge_o(edg)
  );

  assign edg_rise = edg.rise;
  assign edg_fall = edg.fall;

  edcap_trig #(.W(W)) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .pol_i (pol_i),
    .both_i(both_i),
    .edge_i(edg),
    .cnt_o (cnt_q),
    .run_o (run_q)
  );

  // start edge lands while run_q is still low, so it never captures
  assign cap_en = run_q & en_i;

  edcap_bank #(.W(W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_en_i(cap_en),
    .edge_i  (edg),
    .cnt_i   (cnt_q),
    .val_o   (val),
    .vld_o   (vld)
  );

  assign cap_rise_o = val[SLOT_RISE];
  assign cap_fall_o = val[SLOT_FALL];
  assign rise_vld_o = vld[SLOT_RISE];
  assign fall_vld_o = vld[SLOT_FALL];
endmodule

// File: rtl/edcap_timer_chk.sv
module edcap_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         pol_i,
  input logic         both_i,
  input logic [W-1:0] cap_rise_o,
  input logic [W-1:0] cap_fall_o,
  input logic         rise_vld_o,
  input logic         fall_vld_o,
  input logic [W-1:0] cnt,
  input logic         run,
  input logic         edg_rise,
  input logic         edg_fall
);
  a_r2_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && en_i && !both_i && !pol_i && !edg_rise) |=> !run);

  a_r3_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && en_i && !both_i && pol_i && !edg_fall) |=> !run);

  a_r4_any_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && en_i && both_i && (edg_rise || edg_fall)) |=> run);

  a_r5_rise_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_vld_o |-> cap_rise_o == $past(cnt));

  a_r6_fall_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_vld_o |-> cap_fall_o == $past(cnt));

  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && en_i && cnt == {W{1'b1}}) |=> cnt == '0);

  a_r9_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_vld_o |=> !rise_vld_o);

  a_r9_fall_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_vld_o |=> !fall_vld_o);

  a_r10_start_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> (!rise_vld_o && !fall_vld_o && cnt == '0));

  a_r11_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!run && !rise_vld_o && !fall_vld_o));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cap_rise_o) && $stable(cap_fall_o)));
endmodule

bind edcap_timer edcap_timer_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .pol_i     (pol_i),
  .both_i    (both_i),
  .cap_rise_o(cap_rise_o),
  .cap_fall_o(cap_fall_o),
  .rise_vld_o(rise_vld_o),
  .fall_vld_o(fall_vld_o),
  .cnt       (cnt_q),
  .run       (run_q),
  .edg_rise  (edg_rise),
  .edg_fall  (edg_fall)
);

// File: tb/test_edcap_timer.sv
`timescale 1ns/1ps
module test_edcap_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tin = 1'b0, en = 1'b0, pol = 1'b0, both = 1'b0;
  logic [15:0] cap_rise, cap_fall;
  logic        rise_vld, fall_vld;
  int          n_cmp = 0, n_bad = 0;
  int          n_rise = 0, n_fall = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  edcap_timer i_edcap_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tin_i     (tin),
    .en_i      (en),
    .pol_i     (pol),
    .both_i    (both),
    .cap_rise_o(cap_rise),
    .cap_fall_o(cap_fall),
    .rise_vld_o(rise_vld),
    .fall_vld_o(fall_vld)
  );

  typedef struct packed {
    logic        both;
    logic        pol;
    logic        init;
    logic [7:0]  g1;
    logic [7:0]  g2;
    logic [15:0] exp_rise;
    logic [15:0] exp_fall;
    logic [1:0]  n_rise;
    logic [1:0]  n_fall;
  } vec_t;

  // three input toggles at t=0, g1, g1+g2 from level init
  localparam vec_t TBL [6] = '{
    '{1'b0, 1'b0, 1'b0, 8'd5,  8'd7,  16'd11, 16'd4,  2'd1, 2'd1},
    '{1'b0, 1'b1, 1'b0, 8'd6,  8'd9,  16'd8,  16'd0,  2'd1, 2'd0},
    '{1'b0, 1'b0, 1'b1, 8'd4,  8'd10, 16'd0,  16'd9,  2'd0, 2'd1},
    '{1'b0, 1'b1, 1'b1, 8'd8,  8'd3,  16'd7,  16'd10, 2'd1, 2'd1},
    '{1'b1, 1'b0, 1'b1, 8'd12, 8'd5,  16'd11, 16'd16, 2'd1, 2'd1},
    '{1'b1, 1'b1, 1'b0, 8'd3,  8'd3,  16'd5,  16'd2,  2'd1, 2'd1}
  };

  always @(negedge clk) begin
    if (rise_vld) n_rise++;
    if (fall_vld) n_fall++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl);
    rst_n = 1'b0;
    en    = 1'b0;
    tin   = lvl;
    wait_n(2);
    n_rise = 0;
    n_fall = 0;
    rst_n = 1'b1;
    wait_n(5);
  endtask

  function automatic string mode_tag(input vec_t v);
    if (v.both)     return "R4";
    else if (v.pol) return "R3";
    else            return "R2";
  endfunction

  task automatic run_vec(input vec_t v);
    both = v.both;
    pol  = v.pol;
    do_reset(v.init);
    en = 1'b1;
    wait_n(1);
    tin = ~tin;
    wait_n(int'(v.g1));
    tin = ~tin;
    wait_n(int'(v.g2));
    tin = ~tin;
    wait_n(6);
    chk("R5 cap_rise", int'(cap_rise), int'(v.exp_rise));
    chk("R6 cap_fall", int'(cap_fall), int'(v.exp_fall));
    chk({mode_tag(v), " rise count"}, n_rise, int'(v.n_rise));
    chk({mode_tag(v), " fall count"}, n_fall, int'(v.n_fall));
  endtask

  initial begin
    wait_n(1);
    // R1: state while reset is held
    chk("R1 cap_rise", int'(cap_rise), 0);
    chk("R1 cap_fall", int'(cap_fall), 0);
    chk("R1 strobes", int'({rise_vld, fall_vld}), 0);

    for (int i = 0; i < 6; i++) run_vec(TBL[i]);

    // R7, R9: exact strobe cycle and width
    both = 1'b1;
    pol  = 1'b0;
    do_reset(1'b0);
    en = 1'b1;
    wait_n(1);
    tin = 1'b1;
    wait_n(5);
    tin = 1'b0;
    wait_n(2);
    chk("R7 strobe not early", int'(fall_vld), 0);
    wait_n(1);
    chk("R7 strobe on third edge", int'(fall_vld), 1);
    chk("R7 value", int'(cap_fall), 4);
    chk("R7 no rise strobe", int'(rise_vld), 0);
    wait_n(1);
    chk("R9 strobe one cycle", int'(fall_vld), 0);

    // R11: disabled edges do nothing
    wait_n(3);
    en = 1'b0;
    n_rise = 0;
    n_fall = 0;
    wait_n(2);
    tin = 1'b1;
    wait_n(5);
    tin = 1'b0;
    wait_n(6);
    chk("R11 hold cap_fall", int'(cap_fall), 4);
    chk("R11 hold cap_rise", int'(cap_rise), 0);
    chk("R11 no strobes", n_rise + n_fall, 0);

    // R11, R10: re-enable needs a new start, count from 0
    en = 1'b1;
    wait_n(2);
    tin = 1'b1;
    wait_n(7);
    tin = 1'b0;
    wait_n(6);
    chk("R10 start edge not captured", n_rise, 0);
    chk("R11 restart value", int'(cap_fall), 6);
    chk("R11 one capture", n_fall, 1);

    // R8: wrap past 0xFFFF
    both = 1'b0;
    pol  = 1'b0;
    do_reset(1'b0);
    en = 1'b1;
    wait_n(1);
    tin = 1'b1;
    wait_n(65541);
    tin = 1'b0;
    wait_n(6);
    chk("R8 wrapped capture", int'(cap_fall), 4);
    chk("R8 one capture", n_fall, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule